// File: doc/BRIEF.md
# Oversampling Bit-Clock and Data Recovery

This block takes an asynchronous NRZ serial line and recovers both a bit-rate timing strobe and the bit values. It needs no analog loop. A local clock runs at about OSR times the bit rate, where OSR is a power of two and defaults to 8. The local clock has no fixed relation to the transmitter clock, and its exact rate is not critical.

The line first passes through a synchronizer. Every change of the synchronized level, whether rising or falling, yields a one-cycle edge pulse. That pulse forces a small phase counter back to zero. When the line does not change, the counter wraps around freely at OSR. When the counter steps from OSR/2-1 to OSR/2, which is the middle of the bit, the block raises a one-cycle sample strobe and captures the synchronized level into the data output in the same clock edge.

Downstream logic uses the strobe as the recovered bit clock, or as a clock enable, and takes the data output while the strobe is high. Framing and word alignment are handled downstream.

Top module: `osr_clock_recovery`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, `sample_o` and `data_o` become 0, and the phase count and synchronizer history clear. After release with a constant low input, the first strobe is visible after the OSR/2-th rising edge (the 4th at default).
- R2: A change of `serial_i` in either direction restarts the phase. With no further change, `sample_o` is high in the cycle that follows the (SYNC_STAGES+1+OSR/2)-th rising edge after the change (the 7th at default).
- R3: `sample_o` is never high for two cycles in a row. When the line holds its level, the strobe repeats exactly every OSR cycles: the counter wraps from OSR-1 to 0.
- R4: `data_o` changes only in cycles where `sample_o` is high. It then holds the synchronized line level that was present in the cycle before the strobe.
- R5: If a line change is detected in the same cycle that the phase count is OSR/2-1, no strobe follows. The restart takes priority over the sample.
- R6: With a bit period of 7.6 or 8.4 local cycles (a 5% rate error at OSR 8) and runs of at most 6 equal bits, the strobed bits reproduce the sent sequence in order, with no bit missed or doubled.
- R7: When transitions arrive before the counter reaches OSR-1 (bit period shorter than OSR cycles), the early restarts still give exactly one strobe per bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling clock, about OSR times the bit rate |
| rst_i | input | 1 | Synchronous active-high reset |
| serial_i | input | 1 | Raw asynchronous NRZ serial line |
| sample_o | output | 1 | One-cycle recovered bit strobe at mid-bit |
| data_o | output | 1 | Recovered bit, updated with the strobe |

## Verification
The bound checker watches every cycle for the following rules:
- an edge pulse forces the phase to zero;
- the phase advances by one when there is no edge;
- the strobe coincides with the half count and is never longer than one cycle;
- the data output moves only with the strobe and takes the synchronized level;
- a collision at count OSR/2-1 suppresses the sample.

Some properties are sequences over many bits and can only be shown by the bench's scenarios. These are the exact latency from a line change to the strobe, the reset-release timing, and correct recovery of a whole bit stream at 5% rate error in both directions, with no missed or doubled bits.

// File: rtl/cdr_pkg.sv
`timescale 1ns/1ps
package cdr_pkg;

    localparam int unsigned CDR_DEFAULT_OSR    = 8;
    localparam int unsigned CDR_DEFAULT_STAGES = 2;

    // true when v is a non-zero power of two
    function automatic bit cdr_is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/cdr_sync.sv
`timescale 1ns/1ps
// Synchronizer chain plus one history flop; a level change gives a one-cycle pulse.
module cdr_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic serial_i,
    output logic level_o,
    output logic edge_o
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], serial_i};
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.chain[STAGES-1];
    assign edge_o  = st_q.chain[STAGES-1] ^ st_q.prev;

endmodule

// File: rtl/cdr_phase.sv
`timescale 1ns/1ps
// Free-running phase counter, restarted by each edge pulse; registered mid-bit strobe.
module cdr_phase #(
    parameter int unsigned OSR = 8
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   edge_i,
    output logic [$clog2(OSR)-1:0] phase_o,
    output logic                   take_o,
    output logic                   strobe_o
);

    localparam int unsigned CW   = $clog2(OSR);
    localparam int unsigned HALF = OSR / 2;
    localparam logic [CW-1:0] PRE_HALF = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          strobe;
    } phase_t;

    phase_t ph_d, ph_q;
    logic   take;

    // a detected edge has priority over the pending sample
    assign take = !edge_i && (ph_q.cnt == PRE_HALF);

    always_comb begin
        ph_d        = ph_q;
        ph_d.strobe = take;
        if (edge_i) begin
            ph_d.cnt = '0;
        end else begin
            ph_d.cnt = ph_q.cnt + CW'(1);   // power-of-two ratio wraps naturally
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign phase_o  = ph_q.cnt;
    assign take_o   = take;
    assign strobe_o = ph_q.strobe;

endmodule

// File: rtl/cdr_capture.sv
`timescale 1ns/1ps
// Data flop loaded with the synchronized level at the sampling instant.
module cdr_capture (
    input  logic clk_i,
    input  logic rst_i,
    input  logic take_i,
    input  logic level_i,
    output logic bit_o
);

    typedef struct packed {
        logic value;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (take_i) begin
            cap_d.value = level_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign bit_o = cap_q.value;

endmodule

// File: rtl/osr_clock_recovery.sv
`timescale 1ns/1ps
module osr_clock_recovery #(
    parameter int unsigned OSR         = cdr_pkg::CDR_DEFAULT_OSR,
    parameter int unsigned SYNC_STAGES = cdr_pkg::CDR_DEFAULT_STAGES
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic serial_i,
    output logic sample_o,
    output logic data_o
);

    localparam int unsigned CW = $clog2(OSR);

    logic          sync_bit;
    logic          edge_pulse;
    logic [CW-1:0] phase_q;
    logic          take;

    cdr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .serial_i (serial_i),
        .level_o  (sync_bit),
        .edge_o   (edge_pulse)
    );

    cdr_phase #(.OSR(OSR)) u_phase (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .edge_i   (edge_pulse),
        .phase_o  (phase_q),
        .take_o   (take),
        .strobe_o (sample_o)
    );

    cdr_capture u_capture (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .take_i  (take),
        .level_i (sync_bit),
        .bit_o   (data_o)
    );

endmodule

// File: rtl/cdr_checker.sv
`timescale 1ns/1ps
module cdr_checker #(
    parameter int unsigned OSR = 8
) (
    input logic                   clk_i,
    input logic                   rst_i,
    input logic                   sample_o,
    input logic                   data_o,
    input logic                   edge_pulse,
    input logic [$clog2(OSR)-1:0] phase_q,
    input logic                   sync_bit
);

    localparam int unsigned CW = $clog2(OSR);
    localparam logic [CW-1:0] HALF_C = CW'(OSR / 2);
    localparam logic [CW-1:0] PRE_C  = CW'(OSR / 2 - 1);

    p_edge_restart_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        edge_pulse |=> (phase_q == '0));

    p_strobe_at_half_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        sample_o |-> (phase_q == HALF_C));

    p_coast_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        !edge_pulse |=> (phase_q == $past(phase_q) + CW'(1)));

    p_single_strobe_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        sample_o |=> !sample_o);

    p_data_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        !sample_o |-> $stable(data_o));

    p_data_capture_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        sample_o |-> (data_o == $past(sync_bit)));

    p_collision_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (edge_pulse && phase_q == PRE_C) |=> !sample_o);

endmodule

bind osr_clock_recovery cdr_checker #(.OSR(OSR)) u_cdr_checker (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .sample_o   (sample_o),
    .data_o     (data_o),
    .edge_pulse (edge_pulse),
    .phase_q    (phase_q),
    .sync_bit   (sync_bit)
);

// File: tb/test_osr_clock_recovery.sv
`timescale 1ns/1ps
module test_osr_clock_recovery;

    localparam int OSR  = 8;
    localparam int STG  = 2;
    localparam int HALF = OSR / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic smp;
    logic dat;

    always #10 clk = ~clk;   // 50 MHz

    osr_clock_recovery #(.OSR(OSR), .SYNC_STAGES(STG)) i_osr_clock_recovery (
        .clk_i    (clk),
        .rst_i    (rst),
        .serial_i (din),
        .sample_o (smp),
        .data_o   (dat)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int samples[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // behavioural reference: history queue for the synchronizer, integer phase
    int m_hist[$];
    int m_prev, m_cnt, m_stb, m_dat;

    always @(posedge clk) begin
        if (rst) begin
            m_hist.delete();
            for (int i = 0; i < STG; i++) m_hist.push_back(0);
            m_prev = 0; m_cnt = 0; m_stb = 0; m_dat = 0;
        end else begin
            int lvl;
            bit chg;
            lvl   = m_hist[STG-1];
            chg   = (lvl != m_prev);
            m_stb = (!chg && m_cnt == HALF - 1) ? 1 : 0;
            if (m_stb == 1) m_dat = lvl;
            m_cnt  = chg ? 0 : (m_cnt + 1) % OSR;
            m_prev = lvl;
            m_hist.push_front(int'(din));
            void'(m_hist.pop_back());
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            check(smp == m_stb, "R3 strobe vs model", smp, m_stb);
            check(dat == m_dat, "R4 data vs model", dat, m_dat);
            if (smp) samples.push_back(int'(dat));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_strobe();
        int g = 0;
        do begin @(negedge clk); g++; end while (!smp && g < 40);
    endtask

    task automatic count_to_strobe(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!smp && n < 40);
    endtask

    // drive bits with a period given in tenths of a local clock cycle
    task automatic send(input int pat[$], input int tenths);
        int acc = 0;
        foreach (pat[k]) begin
            din = pat[k][0];
            acc += tenths;
            while (acc >= 10) begin @(negedge clk); acc -= 10; end
        end
        cyc(3 * OSR);
    endtask

    function automatic bit contains(input int hay[$], input int pat[$]);
        for (int s = 0; s + pat.size() <= hay.size(); s++) begin
            bit hit = 1;
            foreach (pat[k]) if (hay[s+k] != pat[k]) hit = 0;
            if (hit) return 1;
        end
        return 0;
    endfunction

    initial begin
        #3000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            report();
        end
    end

    initial begin
        int n;
        int cnt;
        int pat[$];
        logic [6:0] lf;
        int run;
        int t_list[3];

        // R1: reset state and first strobe after release
        cyc(3);
        check(smp == 0, "R1 strobe in reset", smp, 0);
        check(dat == 0, "R1 data in reset", dat, 0);
        rst = 1'b0;
        count_to_strobe(n);
        check(n == HALF, "R1 first strobe after release", n, HALF);

        // R2: rising then falling change restarts phase
        for (int p = 0; p < 2; p++) begin
            wait_strobe();
            cyc(2);
            din = ~din;
            count_to_strobe(n);
            check(n == STG + 1 + HALF, p == 0 ? "R2 rising restart" : "R2 falling restart",
                  n, STG + 1 + HALF);
        end

        // R3: free run, one strobe per OSR cycles over ten periods
        wait_strobe();
        cnt = 0;
        for (int c = 0; c < OSR * 10; c++) begin
            @(negedge clk);
            if (smp) cnt++;
        end
        check(cnt == 10, "R3 free-run strobe count", cnt, 10);

        // R5: second change lands when phase is HALF-1
        wait_strobe();
        din = ~din;
        cnt = 0;
        for (int c = 0; c < HALF; c++) begin @(negedge clk); if (smp) cnt++; end
        din = ~din;
        for (int c = 0; c < STG + HALF; c++) begin @(negedge clk); if (smp) cnt++; end
        check(cnt == 0, "R5 suppressed sample count", cnt, 0);
        @(negedge clk);
        check(smp == 1, "R5 strobe after second restart", smp, 1);

        // build a stream with runs capped at 6
        lf = 7'h5b; run = 0;
        for (int k = 0; k < 60; k++) begin
            int b;
            lf = {lf[5:0], lf[6] ^ lf[5]};
            b = lf[0];
            if (k > 0 && b == pat[k-1]) run++; else run = 1;
            if (run > 6) begin b = 1 - b; run = 1; end
            pat.push_back(b);
        end

        // R6 / R7: exact, slow and fast bit periods
        t_list = '{80, 84, 76};
        foreach (t_list[j]) begin
            din = ~pat[0][0];
            cyc(3 * OSR);
            samples.delete();
            send(pat, t_list[j]);
            check(contains(samples, pat), t_list[j] == 76 ? "R7 early restarts stream" : "R6 stream recovery",
                  samples.size(), pat.size());
        end

        report();
    end

endmodule